// File: doc/BRIEF.md
# Doubleword to Narrow Bus Splitter

This block sits between a 32-bit target port and a local bus whose regions may each be 8, 16 or 32 bits wide. It takes one doubleword access (address region, read/write, four byte enables, write data) and replays it as a sequence of local transfers sized to the width configured for that region. Each transfer is presented to a simple local cycle engine through a level request and a per-transfer done pulse. A single completion pulse goes back to the target side once all transfers are finished. For reads, the returned data is reassembled into its original byte lanes.

In narrow regions, the low local address bits and the active-low lane strobes are derived from the byte enables, not passed through. Only lanes that are enabled generate traffic, and transfers run from the lowest byte address upward. Region 4 is the expansion-ROM region. Regions 0 to 3 are ordinary regions. Every region takes its width from its own two-bit field in `cfg_width`.

Top module: `lsplit_top`

## Requirements
- R1: After reset, `acc_busy`, `acc_done` and `loc_req` are all low.
- R2: Region r (0 to NUM_REGIONS-1, region 4 being expansion ROM) takes its width from `cfg_width[2r+1:2r]`: 00 selects 8-bit, 01 selects 16-bit, 10 and 11 select 32-bit. A region index of NUM_REGIONS or above is treated as 32-bit.
- R3: In an 8-bit region, each enabled byte lane l produces one transfer with `loc_addr` = l and `loc_strb_n` = 4'b1110. For a write, `loc_wdata` carries that byte on bits 7:0 and zero above.
- R4: In a 16-bit region, each half h (h=0 for bytes 1:0, h=1 for bytes 3:2) with at least one enabled byte produces one transfer with `loc_addr` = {h,0} and `loc_strb_n` = {2'b11, ~be[2h+1], ~be[2h]}, where bit 0 is the low-byte strobe and bit 1 is the high-byte strobe. For a write, `loc_wdata` carries that halfword on bits 15:0 and zero above.
- R5: In a 32-bit region, an access with any enable produces exactly one transfer with `loc_addr` = 0, `loc_strb_n` = ~`acc_be` and `loc_wdata` = `acc_wdata`.
- R6: Transfers are issued in ascending `loc_addr` order. The next transfer is presented in the cycle after a `loc_done`. While `loc_req` is high and `loc_done` is low, the transfer fields do not change.
- R7: An access with all byte enables low performs no local transfer, and `acc_done` rises in the cycle after it is accepted.
- R8: For reads, `acc_rdata` is valid while `acc_done` is high. Each enabled lane holds the byte returned for it: from `loc_rdata[7:0]` in 8-bit regions, from the matching byte of `loc_rdata[15:0]` in 16-bit regions, and from its own lane in 32-bit regions. Disabled lanes read as zero.
- R9: `acc_done` is a one-cycle pulse in the cycle after the last `loc_done`. `acc_busy` is high from the cycle after acceptance until that cycle, where it is low.
- R10: `acc_start` is accepted only while `acc_busy` is low. A start while busy changes neither the transfer sequence nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2*NUM_REGIONS | Per-region width codes |
| acc_start | input | 1 | Start an access (taken when idle) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_region | input | REGION_W | Target region index |
| acc_be | input | 4 | Byte enables, bit l for lane l |
| acc_wdata | input | 32 | Write data |
| acc_busy | output | 1 | Access in progress |
| acc_done | output | 1 | Access complete pulse |
| acc_rdata | output | 32 | Reassembled read data |
| loc_req | output | 1 | Local transfer request |
| loc_write | output | 1 | Local transfer direction |
| loc_addr | output | 2 | Local address bits 1:0 |
| loc_strb_n | output | 4 | Active-low lane strobes |
| loc_wdata | output | 32 | Steered write data |
| loc_done | input | 1 | Local transfer finished |
| loc_rdata | input | 32 | Local read data |

## Verification
The bench builds the block with its default five regions and a three-bit region index. This setting gives one region for each width code, including the 11 code, and leaves indices 5 to 7 free, so the out-of-range fallback to 32-bit can be reached. The local engine model answers with zero, one or two wait cycles and puts filler on the unused upper read-data bits, which shows that narrow reads pick the correct bits. Starts issued mid-access test that a busy block ignores them.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;
  localparam int NLANE  = 4;
  localparam int LANE_W = 8;
  localparam int DW     = NLANE * LANE_W;
  localparam int IDX_W  = $clog2(NLANE);

  typedef enum logic [1:0] {
    BW8  = 2'b00,
    BW16 = 2'b01,
    BW32 = 2'b10
  } bw_e;

  function automatic bw_e decode_bw(input logic [1:0] code);
    if (code[1])      return BW32;
    else if (code[0]) return BW16;
    else              return BW8;
  endfunction
endpackage

// File: rtl/lsplit_units.sv
module lsplit_units
  import lsplit_pkg::*;
(
  input  bw_e              bw,
  input  logic [NLANE-1:0] be,
  output logic [NLANE-1:0] units
);
  localparam int NHALF = NLANE / 2;

  logic [NHALF-1:0] half_any;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign half_any[h] = |be[2*h +: 2];
  end

  always_comb begin
    units = '0;
    case (bw)
      BW8:     units = be;
      BW16:    units[NHALF-1:0] = half_any;
      default: units[0] = |be;
    endcase
  end
endmodule

// File: rtl/lsplit_pick.sv
module lsplit_pick
  import lsplit_pkg::*;
(
  input  logic [NLANE-1:0] pend,
  output logic [IDX_W-1:0] idx,
  output logic [NLANE-1:0] onehot
);
  always_comb begin
    idx = '0;
    for (int i = NLANE - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
    onehot = NLANE'(1) << idx;
  end
endmodule

// File: rtl/lsplit_steer.sv
module lsplit_steer
  import lsplit_pkg::*;
(
  input  bw_e              bw,
  input  logic [IDX_W-1:0] idx,
  input  logic [NLANE-1:0] be,
  input  logic [DW-1:0]    wdata,
  output logic [1:0]       addr,
  output logic [NLANE-1:0] strb_n,
  output logic [DW-1:0]    data
);
  localparam int HW = 2 * LANE_W;

  always_comb begin
    addr   = '0;
    strb_n = '1;
    data   = '0;
    case (bw)
      BW8: begin
        addr          = idx;
        strb_n[0]     = 1'b0;
        data[LANE_W-1:0] = wdata[LANE_W*idx +: LANE_W];
      end
      BW16: begin
        addr      = {idx[0], 1'b0};
        strb_n[0] = ~be[2*idx[0]];
        strb_n[1] = ~be[2*idx[0] + 1];
        data[HW-1:0] = wdata[HW*idx[0] +: HW];
      end
      default: begin
        addr   = '0;
        strb_n = ~be;
        data   = wdata;
      end
    endcase
  end
endmodule

// File: rtl/lsplit_gather.sv
module lsplit_gather
  import lsplit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap,
  input  bw_e              bw,
  input  logic [IDX_W-1:0] idx,
  input  logic [NLANE-1:0] be,
  input  logic [DW-1:0]    rd_in,
  output logic [DW-1:0]    rd_out
);
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic              hit;
    logic [LANE_W-1:0] src;
    logic [LANE_W-1:0] nxt;
    logic [LANE_W-1:0] q;
    logic              en;

    always_comb begin
      case (bw)
        BW8: begin
          hit = (idx == IDX_W'(l));
          src = rd_in[LANE_W-1:0];
        end
        BW16: begin
          hit = (idx[0] == 1'(l / 2));
          src = rd_in[LANE_W*(l % 2) +: LANE_W];
        end
        default: begin
          hit = 1'b1;
          src = rd_in[LANE_W*l +: LANE_W];
        end
      endcase
      en  = clr | (cap & hit & be[l]);
      nxt = clr ? '0 : src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
    end

    assign rd_out[LANE_W*l +: LANE_W] = q;
  end
endmodule

// File: rtl/lsplit_top.sv
module lsplit_top
  import lsplit_pkg::*;
#(
  parameter int NUM_REGIONS = 5,
  parameter int REGION_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2*NUM_REGIONS-1:0] cfg_width,
  input  logic                     acc_start,
  input  logic                     acc_write,
  input  logic [REGION_W-1:0]      acc_region,
  input  logic [3:0]               acc_be,
  input  logic [31:0]              acc_wdata,
  output logic                     acc_busy,
  output logic                     acc_done,
  output logic [31:0]              acc_rdata,
  output logic                     loc_req,
  output logic                     loc_write,
  output logic [1:0]               loc_addr,
  output logic [3:0]               loc_strb_n,
  output logic [31:0]              loc_wdata,
  input  logic                     loc_done,
  input  logic [31:0]              loc_rdata
);
  typedef enum logic {S_IDLE, S_RUN} st_e;

  st_e              st_q, st_n;
  logic [NLANE-1:0] pend_q, pend_n;
  logic [NLANE-1:0] be_q;
  logic [DW-1:0]    wd_q;
  logic             wr_q;
  bw_e              bw_q;
  bw_e              bw_in;
  logic             done_q, done_n;
  logic [NLANE-1:0] units_in;
  logic [IDX_W-1:0] idx;
  logic [NLANE-1:0] idx_oh;
  logic             accept;
  logic             advance;

  always_comb begin
    bw_in = BW32;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (acc_region == REGION_W'(r)) bw_in = decode_bw(cfg_width[2*r +: 2]);
    end
  end

  lsplit_units u_units (
    .bw    (bw_in),
    .be    (acc_be),
    .units (units_in)
  );

  lsplit_pick u_pick (
    .pend   (pend_q),
    .idx    (idx),
    .onehot (idx_oh)
  );

  lsplit_steer u_steer (
    .bw     (bw_q),
    .idx    (idx),
    .be     (be_q),
    .wdata  (wd_q),
    .addr   (loc_addr),
    .strb_n (loc_strb_n),
    .data   (loc_wdata)
  );

  lsplit_gather u_gather (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .cap    (advance & ~wr_q),
    .bw     (bw_q),
    .idx    (idx),
    .be     (be_q),
    .rd_in  (loc_rdata),
    .rd_out (acc_rdata)
  );

  assign accept  = acc_start & (st_q == S_IDLE);
  assign advance = loc_done & (st_q == S_RUN);

  always_comb begin
    st_n   = st_q;
    pend_n = pend_q;
    done_n = 1'b0;
    if (accept) begin
      pend_n = units_in;
      if (units_in == '0) done_n = 1'b1;
      else                st_n   = S_RUN;
    end else if (advance) begin
      pend_n = pend_q & ~idx_oh;
      if (pend_n == '0) begin
        st_n   = S_IDLE;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      if (accept | advance) pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q <= '0;
      wd_q <= '0;
      wr_q <= 1'b0;
      bw_q <= BW32;
    end else if (accept) begin
      be_q <= acc_be;
      wd_q <= acc_wdata;
      wr_q <= acc_write;
      bw_q <= bw_in;
    end
  end

  assign acc_busy  = (st_q == S_RUN);
  assign acc_done  = done_q;
  assign loc_req   = (st_q == S_RUN);
  assign loc_write = wr_q;
endmodule

// File: rtl/lsplit_chk.sv
module lsplit_chk
  import lsplit_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        acc_start,
  input logic [3:0]  acc_be,
  input logic        acc_busy,
  input logic        acc_done,
  input logic        loc_req,
  input logic        loc_done,
  input logic [1:0]  loc_addr,
  input logic [3:0]  loc_strb_n,
  input logic [31:0] loc_wdata,
  input bw_e         bw
);
  a_r3_byte_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && bw == BW8) |-> (loc_strb_n == 4'b1110));

  a_r4_half_align: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && bw == BW16) |-> (loc_addr[0] == 1'b0 && loc_strb_n[3:2] == 2'b11));

  a_r5_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && bw == BW32) |-> (loc_addr == 2'b00));

  a_r3_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
    loc_req |-> (loc_strb_n != 4'hF));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && $past(loc_req) && $past(loc_done)) |-> (loc_addr > $past(loc_addr)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && !loc_done) |=> (loc_req && $stable(loc_addr) && $stable(loc_strb_n) && $stable(loc_wdata)));

  a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !acc_busy && acc_be == 4'b0000) |=> (acc_done && !acc_busy));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> !acc_busy);
endmodule

bind lsplit_top lsplit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_start  (acc_start),
  .acc_be     (acc_be),
  .acc_busy   (acc_busy),
  .acc_done   (acc_done),
  .loc_req    (loc_req),
  .loc_done   (loc_done),
  .loc_addr   (loc_addr),
  .loc_strb_n (loc_strb_n),
  .loc_wdata  (loc_wdata),
  .bw         (bw_q)
);

// File: tb/sim_lsplit_top.sv
`timescale 1ns/1ps
module sim_lsplit_top;
  localparam int NREG = 5;
  localparam int RW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*NREG-1:0] cfg_width = {2'b01, 2'b11, 2'b10, 2'b01, 2'b00};
  logic acc_start = 0, acc_write = 0;
  logic [RW-1:0] acc_region = '0;
  logic [3:0] acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic acc_busy, acc_done, loc_req, loc_write;
  logic [31:0] acc_rdata, loc_wdata;
  logic [1:0] loc_addr;
  logic [3:0] loc_strb_n;
  logic loc_done = 0;
  logic [31:0] loc_rdata = '0;

  int checks = 0, errors = 0, nresp = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lsplit_top #(.NUM_REGIONS(NREG), .REGION_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
    .acc_start(acc_start), .acc_write(acc_write), .acc_region(acc_region),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_busy(acc_busy),
    .acc_done(acc_done), .acc_rdata(acc_rdata), .loc_req(loc_req),
    .loc_write(loc_write), .loc_addr(loc_addr), .loc_strb_n(loc_strb_n),
    .loc_wdata(loc_wdata), .loc_done(loc_done), .loc_rdata(loc_rdata)
  );

  typedef struct { logic [1:0] a; logic [3:0] s; logic [31:0] d; } xf_t;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int width_of(input int r);
    logic [1:0] c;
    if (r >= NREG) return 32;
    c = cfg_width[2*r +: 2];
    if (c[1]) return 32;
    if (c[0]) return 16;
    return 8;
  endfunction

  task automatic run(input int r, input bit wr, input logic [3:0] be,
                     input logic [31:0] wd, input int wt, input bit poke,
                     input string tag);
    xf_t q[$];
    int w, wc, n;
    bit gave_last, poked, seen_done;
    logic [31:0] exp_rd, rsp;
    w = width_of(r);
    if (w == 8) begin
      for (int l = 0; l < 4; l++)
        if (be[l]) q.push_back('{2'(l), 4'b1110, {24'h0, wd[8*l +: 8]}});
    end else if (w == 16) begin
      for (int h = 0; h < 2; h++)
        if (be[2*h] || be[2*h+1])
          q.push_back('{{1'(h), 1'b0}, {2'b11, ~be[2*h+1], ~be[2*h]}, {16'h0, wd[16*h +: 16]}});
    end else if (be != 0) begin
      q.push_back('{2'b00, ~be, wd});
    end
    exp_rd = '0;
    @(negedge clk);
    check(!acc_busy && !acc_done, "R9", {tag, " idle before start"}, {acc_busy, acc_done}, 0);
    acc_start = 1; acc_write = wr; acc_region = RW'(r); acc_be = be; acc_wdata = wd;
    gave_last = (q.size() == 0);
    wc = 0; n = 0; poked = 0; seen_done = 0;
    while (n < 100) begin
      @(negedge clk);
      n++;
      acc_start = 0;
      loc_done = 0;
      loc_rdata = 32'hDEAD_BEEF;
      if (acc_done) begin
        seen_done = 1;
        check(gave_last, (q.size() == 0 && be == 0) ? "R7" : "R9", {tag, " done timing"}, 1, 0);
        check(!acc_busy, "R9", {tag, " busy at done"}, acc_busy, 0);
        if (!wr) check(acc_rdata == exp_rd, "R8", {tag, " read data"}, acc_rdata, exp_rd);
        break;
      end
      if (gave_last) begin
        check(0, (be == 0) ? "R7" : "R9", {tag, " missing done"}, 0, 1);
        break;
      end
      if (loc_req) begin
        check(acc_busy, "R9", {tag, " busy during transfer"}, acc_busy, 1);
        if (poke && !poked) begin
          poked = 1;
          acc_start = 1; acc_write = ~wr; acc_region = RW'(2); acc_be = 4'hF; acc_wdata = ~wd;
        end
        if (q.size() == 0) begin
          check(0, tag, "extra transfer", {30'h0, loc_addr}, 0);
          break;
        end
        check(loc_addr == q[0].a, tag, "loc_addr", loc_addr, q[0].a);
        check(loc_strb_n == q[0].s, tag, "loc_strb_n", loc_strb_n, q[0].s);
        check(loc_write == wr, tag, "loc_write", loc_write, wr);
        if (wr) check(loc_wdata == q[0].d, tag, "loc_wdata", loc_wdata, q[0].d);
        if (wc == wt) begin
          nresp++;
          rsp = 32'hC3A5_0F00 + nresp * 32'h0103_0507;
          loc_done = 1; loc_rdata = rsp;
          for (int l = 0; l < 4; l++) begin
            if (!be[l]) continue;
            if (w == 8 && l == q[0].a) exp_rd[8*l +: 8] = rsp[7:0];
            if (w == 16 && (l / 2) == q[0].a[1]) exp_rd[8*l +: 8] = rsp[8*(l%2) +: 8];
            if (w == 32) exp_rd[8*l +: 8] = rsp[8*l +: 8];
          end
          void'(q.pop_front());
          wc = 0;
          if (q.size() == 0) gave_last = 1;
        end else begin
          wc++;
        end
      end else begin
        check(0, "R6", {tag, " request missing"}, 0, 1);
        break;
      end
    end
    if (!seen_done) check(0, tag, "access never completed", 0, 1);
    loc_done = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!acc_busy && !acc_done && !loc_req, "R1", "reset state",
          {29'h0, acc_busy, acc_done, loc_req}, 0);
    run(0, 1, 4'hF, 32'h4433_2211, 0, 0, "R3 8b write all");
    run(0, 1, 4'b1010, 32'hA1B2_C3D4, 1, 0, "R3 8b write sparse");
    run(0, 0, 4'hF, 32'h0, 2, 0, "R8 8b read all");
    run(0, 0, 4'b0110, 32'h0, 0, 0, "R8 8b read middle");
    run(1, 1, 4'hF, 32'h8765_4321, 0, 0, "R4 16b write all");
    run(1, 1, 4'b0100, 32'h00AB_0000, 1, 0, "R4 16b write one");
    run(4, 0, 4'b1001, 32'h0, 1, 0, "R4 rom 16b read ends");
    run(1, 0, 4'b0011, 32'h0, 0, 0, "R4 16b read low");
    run(2, 1, 4'b0101, 32'hCAFE_F00D, 0, 0, "R5 32b write");
    run(2, 0, 4'hF, 32'h0, 2, 0, "R5 32b read");
    run(3, 1, 4'b1000, 32'h7700_0000, 0, 0, "R2 code11 as 32b");
    run(6, 0, 4'b1100, 32'h0, 1, 0, "R2 out of range 32b");
    run(0, 1, 4'b0000, 32'h1234_5678, 0, 0, "R7 empty 8b");
    run(1, 0, 4'b0000, 32'h0, 0, 0, "R7 empty 16b");
    run(2, 1, 4'b0000, 32'h0, 0, 0, "R7 empty 32b");
    run(0, 1, 4'hF, 32'h0F1E_2D3C, 1, 1, "R10 start while busy 8b");
    run(1, 0, 4'b1110, 32'h0, 0, 1, "R10 start while busy 16b");
    run(0, 0, 4'b1000, 32'h0, 0, 0, "R6 after ignored start");
    finish_run();
  end
endmodule